// File: doc/BRIEF.md
# Banked Message-Signalled Interrupt Capture Controller

This block turns inbound message-signalled interrupt writes into latched pending vectors and folds them down to one interrupt line. It holds 256 vectors, grouped as 8 banks of 32. Each bank has its own 64-bit message address. When an inbound write hits that address, the write data picks the vector within the bank, and that vector's pending bit is set.

Each bank has a pending word that software clears by writing ones, and a mask that enables single vectors. A bank-enable word gates each bank as a whole. A second-level status word collects one bit per bank and is also cleared by writing ones. That word, masked by a top-level enable, drives the interrupt output. Software reaches all of this through a plain register write strobe with a combinational read-back. Inbound messages arrive on a separate valid/address/data strobe.

A message that matches no bank, or whose data is out of range, is dropped and sets a sticky error output. A new message always wins over a software clear in the same cycle, so no interrupt is lost.

Top module: `msi_bank_ctrl`

## Requirements
- R1: A message with `msg_valid` high, `msg_addr` equal to bank i's address and `msg_data` = v (0..31) sets pending bit v of bank i. No other pending bit changes. The bit reads back one clock later.
- R2: Register map, 32-bit words:
  - bank i has its address-low word at 0xC00+0x10*i, its pending word at 0xC00+0x10*i+0x4 and its vector-enable mask at 0xC00+0x10*i+0x8;
  - its address-high word is at 0xC80+4*i;
  - the top-level enable is at 0x180 and the top-level status at 0x184, with bank i in bit 8+i of both;
  - the bank-enable mask is at 0x190, with bank i in bit i;
  - all other bits and offsets read zero.
  - Address, mask and enable registers read back what was written.
- R3: Writing a word to a bank's pending register clears each pending bit where the word has a 1. Bits where the word has a 0 are unchanged.
- R4: Top-level status bit 8+i becomes set one clock after bank i has its bank-enable bit set and at least one pending vector whose vector-enable bit is set. A pending vector with a clear enable bit, or a disabled bank, raises nothing.
- R5: A top-level status bit stays set after its cause goes away, until software writes a 1 to it. A write-one clear has no effect while the cause is still present.
- R6: `irq` is high exactly when some top-level status bit is set and its top-level enable bit is also set.
- R7: A message for a vector that is already pending leaves the pending word unchanged and raises no error.
- R8: A message whose address matches no bank, or whose data is 32 or greater, changes no pending bit. It sets `msg_err`, which stays high until reset.
- R9: If a message sets a bit in the same clock as a software write-one clear of that bit, the bit stays pending.
- R10: After reset, all registers read zero and `irq` and `msg_err` are low.
- R11: If several banks hold the same address, a message goes only to the lowest-numbered of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_addr | input | 64 | Inbound message address |
| msg_data | input | 32 | Inbound message data (vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| irq | output | 1 | Aggregated interrupt output |
| msg_err | output | 1 | Sticky dropped-message flag |

## Verification
The assertions check the following on every clock:
- a bank hit always leaves its selected vector pending on the next cycle, even with a clear in the same cycle;
- a clear without a hit empties the bits it names;
- the router never steers a message to two banks, and never both drops and delivers it;
- a top-level status bit never rises without a cause in the previous cycle;
- the error flag never falls outside reset.

Only the bench's scenarios can show the rest:
- the register map and its read-back;
- the exhaustive sweep of every bank and vector;
- the interplay of the vector, bank and top-level enables with `irq`;
- the persistence of top-level status after its cause is cleared.

// File: rtl/msi_bank_pkg.sv
// Package: shared widths and register offsets for the banked MSI controller.
// Assumes byte offsets on a 12-bit register port and 32-bit register words.
package msi_bank_pkg;
    localparam int REG_AW       = 12;
    localparam int REG_DW       = 32;
    localparam int MSG_AW       = 64;

    localparam int TOP_EN_OFS   = 'h180;
    localparam int TOP_ST_OFS   = 'h184;
    localparam int BANK_EN_OFS  = 'h190;
    localparam int BANK_BASE    = 'hC00;
    localparam int BANK_STRIDE  = 'h10;
    localparam int FLD_ADDR_LO  = 'h0;
    localparam int FLD_PEND     = 'h4;
    localparam int FLD_VEC_EN   = 'h8;
    localparam int HI_BASE      = 'hC80;
    localparam int HI_STRIDE    = 'h4;
    localparam int TOP_BANK_LSB = 8;

    // Byte offset of one field inside a bank's register group
    function automatic logic [REG_AW-1:0] bank_reg_ofs(input int idx, input int fld);
        return REG_AW'(BANK_BASE + idx * BANK_STRIDE + fld);
    endfunction

    // Byte offset of a bank's upper address word
    function automatic logic [REG_AW-1:0] bank_hi_ofs(input int idx);
        return REG_AW'(HI_BASE + idx * HI_STRIDE);
    endfunction
endpackage

// File: rtl/msi_set_bank.sv
// Module: one vector bank.
// Holds the 64-bit message address, the pending word (software clears it by
// writing ones; an inbound hit has priority over the clear) and the per-vector
// enable mask. active_o reports an enabled pending vector.
// Assumes VEC_PER_SET <= 32 and decoded, single-cycle write strobes.
module msi_set_bank #(
    parameter int VEC_PER_SET = 32,
    parameter int VIDX_W      = $clog2(VEC_PER_SET)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lo_we,
    input  logic                   hi_we,
    input  logic                   pend_we,
    input  logic                   ven_we,
    input  logic [31:0]            wdata,
    input  logic                   hit,
    input  logic [VIDX_W-1:0]      vec,
    output logic [63:0]            addr_o,
    output logic [VEC_PER_SET-1:0] pend_o,
    output logic [VEC_PER_SET-1:0] ven_o,
    output logic                   active_o
);
    logic [31:0]            addr_lo_q;
    logic [31:0]            addr_hi_q;
    logic [VEC_PER_SET-1:0] pend_q;
    logic [VEC_PER_SET-1:0] ven_q;
    logic [VEC_PER_SET-1:0] clr_mask;
    logic [VEC_PER_SET-1:0] set_mask;

    // Build the clear mask from a software write to the pending word
    always_comb clr_mask = pend_we ? wdata[VEC_PER_SET-1:0] : '0;

    // Build the one-hot set mask from an inbound hit
    always_comb set_mask = hit ? (VEC_PER_SET'(1) << vec) : '0;

    // Hold the message address halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else begin
            if (lo_we) addr_lo_q <= wdata;
            if (hi_we) addr_hi_q <= wdata;
        end
    end

    // Update pending bits: clear first, then the hit wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    // Hold the per-vector enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)      ven_q <= '0;
        else if (ven_we) ven_q <= wdata[VEC_PER_SET-1:0];
    end

    assign addr_o   = {addr_hi_q, addr_lo_q};
    assign pend_o   = pend_q;
    assign ven_o    = ven_q;
    assign active_o = |(pend_q & ven_q);

    // R1, R9
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_q[$past(vec)]);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_we && !hit) |=> ((pend_q & $past(wdata[VEC_PER_SET-1:0])) == '0));
endmodule

// File: rtl/msi_msg_router.sv
// Module: steers an inbound message to a bank.
// Compares the message address with every bank address and picks the
// lowest-numbered match. A message is dropped when nothing matches or the data
// is out of vector range. Purely combinational; the clock is used only by checks.
module msi_msg_router #(
    parameter int NUM_SETS    = 8,
    parameter int VEC_PER_SET = 32,
    parameter int VIDX_W      = $clog2(VEC_PER_SET)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msg_valid,
    input  logic [63:0]              msg_addr,
    input  logic [31:0]              msg_data,
    input  logic [NUM_SETS-1:0][63:0] set_addr,
    output logic [NUM_SETS-1:0]      hit,
    output logic [VIDX_W-1:0]        vec,
    output logic                     drop
);
    logic [NUM_SETS-1:0] match;
    logic [NUM_SETS-1:0] first;
    logic                data_ok;

    // Compare each bank address
    for (genvar i = 0; i < NUM_SETS; i++) begin : g_cmp
        assign match[i] = (set_addr[i] == msg_addr);
    end

    // Keep only the lowest-numbered match
    always_comb first = match & (~match + NUM_SETS'(1));

    // Range check on the vector number
    always_comb data_ok = (msg_data < 32'(VEC_PER_SET));

    // Deliver or drop the message
    always_comb begin
        hit  = (msg_valid && data_ok) ? first : '0;
        drop = msg_valid && (!data_ok || (match == '0));
        vec  = msg_data[VIDX_W-1:0];
    end

    // R11
    single_bank_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R8
    drop_excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop && (hit != '0)));
endmodule

// File: rtl/msi_top_agg.sv
// Module: second-level aggregation.
// Holds the bank-enable mask, the top-level enable and the top-level status
// (software clears it by writing ones, but a present cause wins). Drives the
// single interrupt line. Assumes one status bit per bank.
module msi_top_agg #(
    parameter int NUM_SETS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ten_we,
    input  logic                tst_we,
    input  logic                ben_we,
    input  logic [NUM_SETS-1:0] ten_wd,
    input  logic [NUM_SETS-1:0] tst_wd,
    input  logic [NUM_SETS-1:0] ben_wd,
    input  logic [NUM_SETS-1:0] bank_active,
    output logic [NUM_SETS-1:0] ten_o,
    output logic [NUM_SETS-1:0] tst_o,
    output logic [NUM_SETS-1:0] ben_o,
    output logic                irq_o
);
    logic [NUM_SETS-1:0] ten_q;
    logic [NUM_SETS-1:0] tst_q;
    logic [NUM_SETS-1:0] ben_q;
    logic [NUM_SETS-1:0] cause;
    logic [NUM_SETS-1:0] tst_clr;

    // Cause per bank: bank enabled and an enabled vector pending
    always_comb cause = bank_active & ben_q;

    // Clear mask from a software write to the status word
    always_comb tst_clr = tst_we ? tst_wd : '0;

    // Hold the enable masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ten_q <= '0;
            ben_q <= '0;
        end else begin
            if (ten_we) ten_q <= ten_wd;
            if (ben_we) ben_q <= ben_wd;
        end
    end

    // Update status: clear first, then a present cause sets it again
    always_ff @(posedge clk) begin
        if (!rst_n) tst_q <= '0;
        else        tst_q <= (tst_q & ~tst_clr) | cause;
    end

    assign ten_o = ten_q;
    assign tst_o = tst_q;
    assign ben_o = ben_q;
    assign irq_o = |(tst_q & ten_q);

    // R4
    status_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tst_q & ~$past(tst_q) & ~$past(cause)) == '0));
endmodule

// File: rtl/msi_bank_ctrl.sv
// Module: top of the banked MSI controller.
// Decodes the register port, instantiates one bank per set, the message router
// and the top-level aggregator, muxes read data and keeps the sticky error flag.
// Assumes NUM_SETS <= 8 so the banks fit in status bits 15:8.
module msi_bank_ctrl
    import msi_bank_pkg::*;
#(
    parameter int NUM_SETS    = 8,
    parameter int VEC_PER_SET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [MSG_AW-1:0] msg_addr,
    input  logic [31:0]       msg_data,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    output logic              msg_err
);
    localparam int VIDX_W = $clog2(VEC_PER_SET);

    logic [NUM_SETS-1:0][63:0]          set_addr;
    logic [NUM_SETS-1:0][VEC_PER_SET-1:0] pend;
    logic [NUM_SETS-1:0][VEC_PER_SET-1:0] ven;
    logic [NUM_SETS-1:0]                active;
    logic [NUM_SETS-1:0]                hit;
    logic [VIDX_W-1:0]                  vec;
    logic                               drop;
    logic [NUM_SETS-1:0]                ten;
    logic [NUM_SETS-1:0]                tst;
    logic [NUM_SETS-1:0]                ben;
    logic                               err_q;

    // One bank per set with its own decoded write strobes
    for (genvar i = 0; i < NUM_SETS; i++) begin : g_bank
        logic lo_we, hi_we, pend_we, ven_we;
        assign lo_we   = reg_we && (reg_addr == bank_reg_ofs(i, FLD_ADDR_LO));
        assign pend_we = reg_we && (reg_addr == bank_reg_ofs(i, FLD_PEND));
        assign ven_we  = reg_we && (reg_addr == bank_reg_ofs(i, FLD_VEC_EN));
        assign hi_we   = reg_we && (reg_addr == bank_hi_ofs(i));

        msi_set_bank #(.VEC_PER_SET(VEC_PER_SET), .VIDX_W(VIDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo_we    (lo_we),
            .hi_we    (hi_we),
            .pend_we  (pend_we),
            .ven_we   (ven_we),
            .wdata    (reg_wdata),
            .hit      (hit[i]),
            .vec      (vec),
            .addr_o   (set_addr[i]),
            .pend_o   (pend[i]),
            .ven_o    (ven[i]),
            .active_o (active[i])
        );
    end

    msi_msg_router #(.NUM_SETS(NUM_SETS), .VEC_PER_SET(VEC_PER_SET), .VIDX_W(VIDX_W)) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .set_addr  (set_addr),
        .hit       (hit),
        .vec       (vec),
        .drop      (drop)
    );

    msi_top_agg #(.NUM_SETS(NUM_SETS)) u_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .ten_we      (reg_we && (reg_addr == REG_AW'(TOP_EN_OFS))),
        .tst_we      (reg_we && (reg_addr == REG_AW'(TOP_ST_OFS))),
        .ben_we      (reg_we && (reg_addr == REG_AW'(BANK_EN_OFS))),
        .ten_wd      (reg_wdata[TOP_BANK_LSB +: NUM_SETS]),
        .tst_wd      (reg_wdata[TOP_BANK_LSB +: NUM_SETS]),
        .ben_wd      (reg_wdata[NUM_SETS-1:0]),
        .bank_active (active),
        .ten_o       (ten),
        .tst_o       (tst),
        .ben_o       (ben),
        .irq_o       (irq)
    );

    // Read mux: zero for unmapped offsets and bits
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(TOP_EN_OFS)) reg_rdata[TOP_BANK_LSB +: NUM_SETS] = ten;
        if (reg_addr == REG_AW'(TOP_ST_OFS)) reg_rdata[TOP_BANK_LSB +: NUM_SETS] = tst;
        if (reg_addr == REG_AW'(BANK_EN_OFS)) reg_rdata[NUM_SETS-1:0] = ben;
        for (int i = 0; i < NUM_SETS; i++) begin
            if (reg_addr == bank_reg_ofs(i, FLD_ADDR_LO)) reg_rdata = set_addr[i][31:0];
            if (reg_addr == bank_hi_ofs(i))               reg_rdata = set_addr[i][63:32];
            if (reg_addr == bank_reg_ofs(i, FLD_PEND))    reg_rdata[VEC_PER_SET-1:0] = pend[i];
            if (reg_addr == bank_reg_ofs(i, FLD_VEC_EN))  reg_rdata[VEC_PER_SET-1:0] = ven[i];
        end
    end

    // Sticky error on any dropped message
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | drop;
    end

    assign msg_err = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |=> msg_err);

    // R8
    drop_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> msg_err);
endmodule

// File: tb/msi_bank_ctrl_test.sv
// Bench: exhaustive bank/vector sweep plus enable, clear, race and error scenarios.
module msi_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        msg_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    msi_bank_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .msg_err   (msg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] lo_of(input int s);   return 12'(12'hC00 + s*16);     endfunction
    function automatic logic [11:0] pnd_of(input int s);  return 12'(12'hC00 + s*16 + 4); endfunction
    function automatic logic [11:0] ven_of(input int s);  return 12'(12'hC00 + s*16 + 8); endfunction
    function automatic logic [11:0] hi_of(input int s);   return 12'(12'hC80 + s*4);      endfunction
    function automatic logic [63:0] maddr(input int s);
        return {32'(32'hA0 + s), 32'(32'h1000_0000 + s*16)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_data = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    // Message and software clear in the same clock
    task automatic race(input int s, input logic [31:0] d, input logic [31:0] clr);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = maddr(s); msg_data = d;
        reg_we = 1'b1; reg_addr = pnd_of(s); reg_wdata = clr;
        @(negedge clk);
        msg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        rst_n = 1'b0; msg_valid = 1'b0; msg_addr = '0; msg_data = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        do_reset();

        // R10: reset state
        chk("R10 irq", 32'(irq), 0);
        chk("R10 err", 32'(msg_err), 0);
        rd(12'h180, rv); chk("R10 top enable", rv, 0);
        rd(12'h184, rv); chk("R10 top status", rv, 0);
        rd(12'h190, rv); chk("R10 bank enable", rv, 0);
        for (int s = 0; s < 8; s++) begin
            rd(pnd_of(s), rv); chk("R10 pending", rv, 0);
            rd(lo_of(s), rv);  chk("R10 addr lo", rv, 0);
        end

        // R2: program bank addresses and read back
        for (int s = 0; s < 8; s++) begin
            wr(lo_of(s), maddr(s)[31:0]);
            wr(hi_of(s), maddr(s)[63:32]);
        end
        for (int s = 0; s < 8; s++) begin
            rd(lo_of(s), rv); chk("R2 addr lo", rv, maddr(s)[31:0]);
            rd(hi_of(s), rv); chk("R2 addr hi", rv, maddr(s)[63:32]);
        end
        wr(ven_of(4), 32'h1234_5678);
        rd(ven_of(4), rv); chk("R2 vector enable", rv, 32'h1234_5678);
        wr(ven_of(4), 0);
        wr(12'h190, 32'hFFFF_FF5A);
        rd(12'h190, rv); chk("R2 bank enable bits 7:0", rv, 32'h5A);
        wr(12'h180, 32'hFFFF_FFFF);
        rd(12'h180, rv); chk("R2 top enable bits 15:8", rv, 32'h0000_FF00);
        wr(12'h180, 0); wr(12'h190, 0);
        rd(12'h194, rv); chk("R2 unmapped", rv, 0);

        // R1 / R3: every bank and vector
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 32; v++) begin
                send(maddr(s), 32'(v));
                rd(pnd_of(s), rv);           chk("R1 pending bit", rv, 32'(1) << v);
                rd(pnd_of((s + 1) % 8), rv); chk("R1 other bank", rv, 0);
                wr(pnd_of(s), 32'(1) << v);
                rd(pnd_of(s), rv);           chk("R3 cleared", rv, 0);
            end
        end

        // R3: partial clear and a write of zero
        send(maddr(2), 3); send(maddr(2), 7); send(maddr(2), 20);
        wr(pnd_of(2), 32'h0000_0088);
        rd(pnd_of(2), rv); chk("R3 partial clear", rv, 32'(1) << 20);
        wr(pnd_of(2), 0);
        rd(pnd_of(2), rv); chk("R3 zero write", rv, 32'(1) << 20);

        // R4: gating by vector enable and bank enable
        tick(2);
        rd(12'h184, rv); chk("R4 nothing enabled", rv, 0);
        wr(ven_of(2), 32'(1) << 20);
        tick(2);
        rd(12'h184, rv); chk("R4 bank disabled", rv, 0);
        wr(ven_of(2), 32'(1) << 5);
        wr(12'h190, 32'hFF);
        tick(2);
        rd(12'h184, rv); chk("R4 vector disabled", rv, 0);
        wr(ven_of(2), 32'(1) << 20);
        tick(1);
        rd(12'h184, rv); chk("R4 status raised", rv, 32'(1) << 10);

        // R6: interrupt gating by top enable
        chk("R6 irq off while disabled", 32'(irq), 0);
        wr(12'h180, 32'(1) << 11);
        chk("R6 other enable", 32'(irq), 0);
        wr(12'h180, 32'(1) << 10);
        chk("R6 irq on", 32'(irq), 1);

        // R5: status persists after its cause goes away, clears on write-one
        wr(pnd_of(2), 32'(1) << 20);
        tick(2);
        rd(12'h184, rv); chk("R5 status held", rv, 32'(1) << 10);
        chk("R6 irq held", 32'(irq), 1);
        wr(12'h184, 32'(1) << 10);
        rd(12'h184, rv); chk("R5 status cleared", rv, 0);
        chk("R6 irq dropped", 32'(irq), 0);
        send(maddr(2), 20);
        tick(1);
        wr(12'h184, 32'(1) << 10);
        rd(12'h184, rv); chk("R5 clear while cause present", rv, 32'(1) << 10);
        wr(pnd_of(2), 32'(1) << 20);
        tick(1);
        wr(12'h184, 32'h0000_FF00);
        rd(12'h184, rv); chk("R5 final clear", rv, 0);

        // R7: duplicate message
        send(maddr(5), 9); send(maddr(5), 9);
        rd(pnd_of(5), rv); chk("R7 duplicate absorbed", rv, 32'(1) << 9);
        chk("R7 no error", 32'(msg_err), 0);

        // R9: message and clear in the same clock
        race(5, 9, 32'(1) << 9);
        rd(pnd_of(5), rv); chk("R9 same bit kept", rv, 32'(1) << 9);
        race(5, 10, 32'(1) << 9);
        rd(pnd_of(5), rv); chk("R9 other bit", rv, 32'(1) << 10);

        // R11: shared address goes to lowest bank
        wr(lo_of(7), maddr(6)[31:0]);
        wr(hi_of(7), maddr(6)[63:32]);
        send(maddr(6), 4);
        rd(pnd_of(6), rv); chk("R11 lower bank", rv, 32'(1) << 4);
        rd(pnd_of(7), rv); chk("R11 higher bank", rv, 0);

        // R8: unmatched address
        chk("R8 err clear before", 32'(msg_err), 0);
        send(64'hDEAD_BEEF_0000_0000, 1);
        chk("R8 err set (address)", 32'(msg_err), 1);
        rd(pnd_of(0), rv); chk("R8 no pending", rv, 0);
        rd(pnd_of(5), rv); chk("R8 others untouched", rv, 32'(1) << 10);
        tick(3);
        chk("R8 err sticky", 32'(msg_err), 1);

        // R10 again, then R8 out-of-range data
        do_reset();
        chk("R10 err after reset", 32'(msg_err), 0);
        rd(pnd_of(5), rv); chk("R10 pending after reset", rv, 0);
        send(64'h0, 32);
        chk("R8 err set (data 32)", 32'(msg_err), 1);
        rd(pnd_of(0), rv); chk("R8 data 32 dropped", rv, 0);
        do_reset();
        send(64'h0, 32'hFFFF_FFFF);
        chk("R8 err set (data max)", 32'(msg_err), 1);
        rd(pnd_of(0), rv); chk("R8 data max dropped", rv, 0);
        send(64'h0, 31);
        rd(pnd_of(0), rv); chk("R1 reset address hits bank 0", rv, 32'(1) << 31);

        finish_run();
    end
endmodule